// File: doc/BRIEF.md
# Inter-Core Interrupt Generator

This block raises interrupts from one core of a small cluster to another. Every core has its own command port, made of an opcode and a core-number argument, and its own readback register. Through that port a core can post an interrupt to a peer. It can ask whether a peer still holds an unacknowledged interrupt from it. When it is the receiver, it can fetch the mask of cores that interrupted it and acknowledge those senders one at a time.

Internally, pending state is a square matrix with one row per receiver and one column per sender. A receiver's interrupt line is the OR of its row. Posts from several senders therefore merge onto one line, while each sender stays individually visible and individually clearable. An interrupt never travels from a core to itself. If a post and an acknowledge land on the same matrix bit in one cycle, the post wins, so no interrupt is lost.

Opcodes are 3 bits per core: 0 idle, 1 post, 2 query, 3 source, 4 acknowledge. The codes 5, 6 and 7 are undefined. Core c uses opcode bits [3c+2:3c], argument bits [2c+1:2c] and readback bits [4c+3:4c] (values for the default of 4 cores).

Top module: `xcore_irq_gen`

## Requirements
- R1: Reset (active-low, asynchronous) clears every pending bit, drives every interrupt line low and zeroes every readback register.
- R2: A post from core s with argument r, where r differs from s, sets pending bit (r, s). Interrupt line r is high from the next clock edge.
- R3: A post whose argument equals the issuing core leaves every interrupt line and every pending bit unchanged.
- R4: A query from core c with argument t loads readback c with 1 in bit 0 if bit (t, c) is pending, and 0 otherwise. The upper bits are 0. The value reflects the state before that cycle's updates.
- R5: A source command from core c loads readback c with row c of the matrix, where bit s is set when sender s is pending.
- R6: Posts from several senders to one receiver in the same cycle all become pending, share one interrupt line and show as several bits in the source mask.
- R7: An acknowledge from core r with argument s clears only bit (r, s). Line r stays high until every bit of row r has been cleared.
- R8: When a post and an acknowledge address the same bit in one cycle, the bit ends up set.
- R9: A readback register changes only one cycle after its own core issues a query or source command. Idle and undefined opcodes (5, 6, 7) change no readback and no pending state.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cmd_op | input | N*3 | Per-core opcode |
| cmd_arg | input | N*IDW | Per-core core-number argument |
| rdbk | output | N*N | Per-core readback register |
| irq_out | output | N | Per-core interrupt line |

## Verification
The assertions assume that every core presents at most one opcode per cycle and that its argument names a core that exists, so a post or query always has a valid matrix row. The bench drives only core numbers 0 to 3 and changes inputs on the falling edge. Every opcode is therefore stable around the rising edge that acts on it. The stimulus covers merged posts, a same-cycle post and acknowledge, self-posts and the undefined opcodes.

// File: rtl/xcore_irq_gen.sv
module xcore_irq_gen #(
  parameter int N = 4,
  localparam int IDW = (N > 1) ? $clog2(N) : 1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [N*3-1:0]   cmd_op,
  input  logic [N*IDW-1:0] cmd_arg,
  output logic [N*N-1:0]   rdbk,
  output logic [N-1:0]     irq_out
);
  localparam logic [2:0] OP_POST = 3'd1;
  localparam logic [2:0] OP_QRY  = 3'd2;
  localparam logic [2:0] OP_SRC  = 3'd3;
  localparam logic [2:0] OP_ACK  = 3'd4;

  logic [N-1:0] pend   [N];
  logic [N-1:0] pend_d [N];

  always_comb begin
    for (int r = 0; r < N; r++) begin
      for (int s = 0; s < N; s++) begin
        pend_d[r][s] = (r != s && cmd_op[3*s +: 3] == OP_POST && cmd_arg[IDW*s +: IDW] == IDW'(r))
                     | (pend[r][s] & ~(cmd_op[3*r +: 3] == OP_ACK && cmd_arg[IDW*r +: IDW] == IDW'(s)));
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int r = 0; r < N; r++) pend[r] <= '0;
    end else begin
      for (int r = 0; r < N; r++) pend[r] <= pend_d[r];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rdbk <= '0;
    end else begin
      for (int c = 0; c < N; c++) begin
        case (cmd_op[3*c +: 3])
          OP_QRY:  rdbk[N*c +: N] <= {{(N-1){1'b0}}, pend[cmd_arg[IDW*c +: IDW]][c]};
          OP_SRC:  rdbk[N*c +: N] <= pend[c];
          default: ;
        endcase
      end
    end
  end

  for (genvar r = 0; r < N; r++) begin : g_row
    assign irq_out[r] = |pend[r];

    AST_RB_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      !(cmd_op[3*r +: 3] == OP_QRY || cmd_op[3*r +: 3] == OP_SRC) |=> $stable(rdbk[N*r +: N])); // R9

    AST_IRQ_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      (irq_out[r] && cmd_op[3*r +: 3] != OP_ACK) |=> irq_out[r]); // R7

    for (genvar s = 0; s < N; s++) begin : g_col
      if (r != s) begin : g_peer
        AST_POST_SETS: assert property (@(posedge clk) disable iff (!rst_n)
          (cmd_op[3*s +: 3] == OP_POST && cmd_arg[IDW*s +: IDW] == IDW'(r)) |=> pend[r][s]); // R8
      end
      AST_ACK_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_op[3*r +: 3] == OP_ACK && cmd_arg[IDW*r +: IDW] == IDW'(s) &&
         !(cmd_op[3*s +: 3] == OP_POST && cmd_arg[IDW*s +: IDW] == IDW'(r))) |=> !pend[r][s]); // R7
    end
  end
endmodule

// File: tb/xcore_irq_gen_tb.sv
module xcore_irq_gen_tb_top;
  localparam int CLK_P = 10;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [11:0] cmd_op = '0;
  logic [7:0]  cmd_arg = '0;
  logic [15:0] rdbk;
  logic [3:0]  irq_out;

  int n_cmp = 0;
  int n_bad = 0;
  bit done = 1'b0;

  always #(CLK_P/2) clk = ~clk;

  xcore_irq_gen #(.N(4)) dut_i (
    .clk(clk), .rst_n(rst_n), .cmd_op(cmd_op), .cmd_arg(cmd_arg),
    .rdbk(rdbk), .irq_out(irq_out));

  typedef struct packed {
    logic [11:0] op;
    logic [7:0]  arg;
    logic [1:0]  who;
    logic [3:0]  irq;
    logic [3:0]  rb;
    logic [7:0]  tag;
  } vec_t;

  // op/arg concatenations list core3 first; rb is readback of core "who"
  localparam vec_t TBL [19] = '{
    '{ {3'd0,3'd0,3'd0,3'd0}, {2'd0,2'd0,2'd0,2'd0}, 2'd0, 4'b0000, 4'b0000, 8'd9 }, // R9 idle
    '{ {3'd0,3'd0,3'd0,3'd1}, {2'd0,2'd0,2'd0,2'd1}, 2'd0, 4'b0010, 4'b0000, 8'd2 }, // R2
    '{ {3'd0,3'd0,3'd3,3'd0}, {2'd0,2'd0,2'd0,2'd0}, 2'd1, 4'b0010, 4'b0001, 8'd5 }, // R5
    '{ {3'd0,3'd2,3'd0,3'd0}, {2'd0,2'd1,2'd0,2'd0}, 2'd2, 4'b0010, 4'b0000, 8'd4 }, // R4 not pending
    '{ {3'd0,3'd0,3'd0,3'd2}, {2'd0,2'd0,2'd0,2'd1}, 2'd0, 4'b0010, 4'b0001, 8'd4 }, // R4 pending
    '{ {3'd1,3'd1,3'd0,3'd0}, {2'd1,2'd1,2'd0,2'd0}, 2'd0, 4'b0010, 4'b0001, 8'd6 }, // R6 merge
    '{ {3'd0,3'd0,3'd3,3'd0}, {2'd0,2'd0,2'd0,2'd0}, 2'd1, 4'b0010, 4'b1101, 8'd6 }, // R6 mask
    '{ {3'd0,3'd0,3'd4,3'd0}, {2'd0,2'd0,2'd0,2'd0}, 2'd1, 4'b0010, 4'b1101, 8'd7 }, // R7
    '{ {3'd0,3'd1,3'd4,3'd0}, {2'd0,2'd1,2'd2,2'd0}, 2'd1, 4'b0010, 4'b1101, 8'd8 }, // R8
    '{ {3'd0,3'd0,3'd3,3'd0}, {2'd0,2'd0,2'd0,2'd0}, 2'd1, 4'b0010, 4'b1100, 8'd8 }, // R8 survived
    '{ {3'd0,3'd0,3'd4,3'd0}, {2'd0,2'd0,2'd2,2'd0}, 2'd1, 4'b0010, 4'b1100, 8'd7 }, // R7
    '{ {3'd0,3'd0,3'd4,3'd0}, {2'd0,2'd0,2'd3,2'd0}, 2'd1, 4'b0000, 4'b1100, 8'd7 }, // R7 last
    '{ {3'd0,3'd0,3'd3,3'd0}, {2'd0,2'd0,2'd0,2'd0}, 2'd1, 4'b0000, 4'b0000, 8'd5 }, // R5 empty
    '{ {3'd1,3'd0,3'd0,3'd0}, {2'd3,2'd0,2'd0,2'd0}, 2'd3, 4'b0000, 4'b0000, 8'd3 }, // R3
    '{ {3'd0,3'd0,3'd0,3'd1}, {2'd0,2'd0,2'd0,2'd3}, 2'd3, 4'b1000, 4'b0000, 8'd2 }, // R2
    '{ {3'd3,3'd0,3'd0,3'd0}, {2'd0,2'd0,2'd0,2'd0}, 2'd3, 4'b1000, 4'b0001, 8'd5 }, // R5
    '{ {3'd7,3'd0,3'd0,3'd0}, {2'd0,2'd0,2'd0,2'd0}, 2'd3, 4'b1000, 4'b0001, 8'd9 }, // R9 undefined
    '{ {3'd5,3'd0,3'd0,3'd0}, {2'd2,2'd0,2'd0,2'd0}, 2'd3, 4'b1000, 4'b0001, 8'd9 }, // R9 undefined
    '{ {3'd4,3'd0,3'd0,3'd0}, {2'd0,2'd0,2'd0,2'd0}, 2'd3, 4'b0000, 4'b0001, 8'd7 }  // R7
  };

  task automatic check(input string what, input int tag, input logic [15:0] act, input logic [15:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL R%0d %s: actual %h expected %h", tag, what, act, exp);
    end
  endtask

  task automatic finish_run();
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  endtask

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk);
    check("irq in reset", 1, {12'h0, irq_out}, 16'h0);   // R1
    check("rdbk in reset", 1, rdbk, 16'h0);              // R1
    rst_n = 1'b1;
    for (int i = 0; i < 19; i++) begin
      cmd_op  = TBL[i].op;
      cmd_arg = TBL[i].arg;
      @(posedge clk);
      @(negedge clk);
      check($sformatf("irq row %0d", i), TBL[i].tag, {12'h0, irq_out}, {12'h0, TBL[i].irq});
      check($sformatf("rdbk row %0d", i), TBL[i].tag, {12'h0, rdbk[TBL[i].who*4 +: 4]}, {12'h0, TBL[i].rb});
    end
    cmd_op = {3'd0,3'd0,3'd0,3'd1}; cmd_arg = {2'd0,2'd0,2'd0,2'd2};
    @(posedge clk); @(negedge clk);
    cmd_op = '0;
    check("post to core2", 2, {12'h0, irq_out}, 16'h0004);  // R2
    rst_n = 1'b0;
    #1;
    check("irq after reset", 1, {12'h0, irq_out}, 16'h0);   // R1
    check("rdbk after reset", 1, rdbk, 16'h0);              // R1
    @(negedge clk);
    rst_n = 1'b1;
    cmd_op = {3'd0,3'd3,3'd0,3'd0};
    @(posedge clk); @(negedge clk);
    check("source after reset", 1, {12'h0, rdbk[8 +: 4]}, 16'h0);  // R1
    done = 1'b1;
    finish_run();
  end

  initial begin
    #(CLK_P * 100000);
    if (!done) begin
      n_cmp++;
      n_bad++;
      $display("FAIL watchdog: actual timeout expected completion");
      finish_run();
    end
  end
endmodule